// File: doc/BRIEF.md
# Flash Block Erase and Verify Sequencer

This controller erases a single flash block and then proves the erase by reading the block back. It drives the control strobes of a flash array: a software write-enable, an erase-setup line, the erase line itself, an erase-verify line, and an enable for an external watchdog. Each strobe is switched in a fixed order, and a programmable settling delay follows each switch. After each erase attempt the controller walks every word address of the block. At each address it issues a dummy write of 0xFF, waits, and reads one 16-bit word. A word counts as erased only when all of its bits are ones.

A failed verify triggers a fresh erase attempt. Attempts continue until the attempt limit is reached, and the controller then reports failure. A successful verify ends in a done pulse. Every delay comes from its own cycle-count input and is timed by one shared down-counter. A block-select mask must name exactly one block. Any other mask is refused at once, and no strobe moves. A sticky status field holds the outcome of the last operation until the next accepted start.

Top module: `flash_erase_seq`

## Requirements
- R1: A start while idle is accepted only when `blk_mask` has exactly one bit set. With zero or several bits set, `fail` pulses in the next cycle, `busy` and every strobe stay low, and `status` becomes 2'b11 (rejected).
- R2: After an accepted start, `write_en` is high alone for `dly_wen_on`+1 cycles before `wdog_en` and `erase_setup` rise.
- R3: Each attempt keeps `wdog_en` and `erase_setup` high for `dly_setup`+1 cycles, then adds `erase_on` for `dly_erase`+1 cycles. It then drops `erase_on` and holds for `dly_erase_off`+1 cycles, then drops `erase_setup` and holds for `dly_setup_off`+1 cycles. `erase_on` is high only while `erase_setup`, `wdog_en` and `write_en` are high, and `wdog_en` is low whenever `verify_on` is high.
- R4: `verify_on` is high for `dly_verify_on`+1 cycles before the first dummy write. Each word takes one `dummy_wr` cycle with `dummy_data` = 8'hFF, then `dly_read`+1 settle cycles, then one read cycle. `vaddr` starts at `blk_first` in every attempt and steps by one word up to `blk_last`.
- R5: A read word passes only if it equals 16'hFFFF. The first failing word ends that attempt's verify walk.
- R6: When the whole block passes, `verify_on` drops for `dly_verify_off`+1 cycles, then `write_en` drops for `dly_wen_off`+1 cycles, then `done` pulses and `status` becomes 2'b01.
- R7: The attempt count starts at 1. After a failed verify and `dly_verify_off`+1 cycles, a new attempt starts if the count is below `try_limit`, and the count increments. Otherwise `write_en` drops for `dly_wen_off`+1 cycles, then `fail` pulses and `status` becomes 2'b10. The number of attempts is never more than max(`try_limit`, 1).
- R8: `busy` is high from the cycle after an accepted start until the cycle in which `done` or `fail` pulses. A start while busy is ignored.
- R9: `done` and `fail` are never high together, and `done` lasts one cycle. `status` reads 2'b00 while a run is in progress and holds its value after the run.
- R10: The busy time is (x+1) + θ+1 plus, for each attempt, (y+z+α+β+γ+5) + (η+1) + W·(ε+3). Here x is `dly_wen_on`, y is `dly_setup`, z is `dly_erase`, α is `dly_erase_off`, β is `dly_setup_off`, γ is `dly_verify_on`, ε is `dly_read`, η is `dly_verify_off` and θ is `dly_wen_off`. W is the number of words read in that attempt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start request, sampled while idle |
| blk_mask | input | NBLK | Block select, must be one-hot |
| blk_first | input | AW | First word address of the block |
| blk_last | input | AW | Last word address of the block |
| dly_wen_on | input | CW | Wait after write-enable rises (x) |
| dly_setup | input | CW | Wait after erase-setup rises (y) |
| dly_erase | input | CW | Erase pulse length (z) |
| dly_erase_off | input | CW | Wait after erase falls (α) |
| dly_setup_off | input | CW | Wait after erase-setup falls (β) |
| dly_verify_on | input | CW | Wait after erase-verify rises (γ) |
| dly_read | input | CW | Wait between dummy write and read (ε) |
| dly_verify_off | input | CW | Wait after erase-verify falls (η) |
| dly_wen_off | input | CW | Wait after write-enable falls (θ) |
| try_limit | input | TW | Maximum erase attempts (N) |
| vdata | input | 16 | Verify read data from the array |
| write_en | output | 1 | Software write-enable strobe |
| erase_setup | output | 1 | Erase-setup strobe |
| erase_on | output | 1 | Erase strobe |
| verify_on | output | 1 | Erase-verify strobe |
| wdog_en | output | 1 | Watchdog enable |
| vaddr | output | AW | Verify word address |
| dummy_wr | output | 1 | Dummy-write strobe |
| dummy_data | output | 8 | Dummy-write data (always 0xFF) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle success pulse |
| fail | output | 1 | One-cycle failure or reject pulse |
| status | output | 2 | Sticky result: 00 none/running, 01 erased, 10 failed, 11 rejected |

## Verification
The assertions check the strobe nesting on every cycle. Erase is high only inside setup, write-enable and the watchdog window. Verify and the watchdog are never high together, and dummy writes occur only during verify. They also check the reject response to a bad mask, the status tied to each result pulse, and that the pulses are exclusive and short. What only the bench's scenarios can show is the timing and the flow. That covers each delay's exact length, the address walk and its restart, the number of attempts for a given pattern of stubborn words, and the total busy time. The bench covers these against an array model in which each word becomes erased only after a chosen number of erase pulses.

// File: rtl/erase_pkg.sv
package erase_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_WEN, ST_SETUP, ST_ERASE, ST_EOFF, ST_SOFF, ST_VON,
    ST_DUMMY, ST_SETTLE, ST_READ, ST_VOFF_OK, ST_VOFF_NG,
    ST_WOFF_OK, ST_WOFF_NG
  } seq_state_t;

  localparam logic [1:0] STAT_NONE   = 2'b00;
  localparam logic [1:0] STAT_PASS   = 2'b01;
  localparam logic [1:0] STAT_FAIL   = 2'b10;
  localparam logic [1:0] STAT_REJECT = 2'b11;

  localparam logic [7:0] DUMMY_BYTE = 8'hFF;

  function automatic logic word_erased(input logic [15:0] w);
    return &w;
  endfunction

endpackage

// File: rtl/seq_wait_timer.sv
module seq_wait_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/seq_addr_walk.sv
module seq_addr_walk #(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          inc,
  input  logic [AW-1:0] first,
  input  logic [AW-1:0] last,
  output logic [AW-1:0] addr,
  output logic          at_end
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    addr <= '0;
    else if (load) addr <= first;
    else if (inc)  addr <= addr + 1'b1;
  end

  assign at_end = (addr >= last);
endmodule

// File: rtl/seq_try_count.sv
module seq_try_count #(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          inc,
  input  logic [TW-1:0] limit,
  output logic          at_limit
);
  logic [TW-1:0] n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     n <= TW'(1);
    else if (clear) n <= TW'(1);
    else if (inc)   n <= n + 1'b1;
  end

  assign at_limit = (n >= limit);
endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
  import erase_pkg::*;
#(
  parameter int AW   = 12,
  parameter int CW   = 8,
  parameter int TW   = 4,
  parameter int NBLK = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [NBLK-1:0] blk_mask,
  input  logic [AW-1:0]   blk_first,
  input  logic [AW-1:0]   blk_last,
  input  logic [CW-1:0]   dly_wen_on,
  input  logic [CW-1:0]   dly_setup,
  input  logic [CW-1:0]   dly_erase,
  input  logic [CW-1:0]   dly_erase_off,
  input  logic [CW-1:0]   dly_setup_off,
  input  logic [CW-1:0]   dly_verify_on,
  input  logic [CW-1:0]   dly_read,
  input  logic [CW-1:0]   dly_verify_off,
  input  logic [CW-1:0]   dly_wen_off,
  input  logic [TW-1:0]   try_limit,
  input  logic [15:0]     vdata,
  output logic            write_en,
  output logic            erase_setup,
  output logic            erase_on,
  output logic            verify_on,
  output logic            wdog_en,
  output logic [AW-1:0]   vaddr,
  output logic            dummy_wr,
  output logic [7:0]      dummy_data,
  output logic            busy,
  output logic            done,
  output logic            fail,
  output logic [1:0]      status
);
  seq_state_t st, st_n;

  // named internal events
  logic t_exp, at_end, at_limit, mask_ok;
  logic start_accept, start_reject, word_ok, word_bad;
  logic addr_load, addr_inc, retry, finish_ok, finish_ng;
  logic          t_load;
  logic [CW-1:0] t_val;

  assign mask_ok      = $onehot(blk_mask);
  assign start_accept = (st == ST_IDLE) && start && mask_ok;
  assign start_reject = (st == ST_IDLE) && start && !mask_ok;
  assign word_ok      = (st == ST_READ) && word_erased(vdata);
  assign word_bad     = (st == ST_READ) && !word_erased(vdata);
  assign addr_load    = (st == ST_VON) && t_exp;
  assign addr_inc     = word_ok && !at_end;
  assign retry        = (st == ST_VOFF_NG) && t_exp && !at_limit;
  assign finish_ok    = (st == ST_WOFF_OK) && t_exp;
  assign finish_ng    = (st == ST_WOFF_NG) && t_exp;

  always_comb begin
    st_n = st;
    case (st)
      ST_IDLE:    if (start_accept) st_n = ST_WEN;
      ST_WEN:     if (t_exp) st_n = ST_SETUP;
      ST_SETUP:   if (t_exp) st_n = ST_ERASE;
      ST_ERASE:   if (t_exp) st_n = ST_EOFF;
      ST_EOFF:    if (t_exp) st_n = ST_SOFF;
      ST_SOFF:    if (t_exp) st_n = ST_VON;
      ST_VON:     if (t_exp) st_n = ST_DUMMY;
      ST_DUMMY:   st_n = ST_SETTLE;
      ST_SETTLE:  if (t_exp) st_n = ST_READ;
      ST_READ: begin
        if (word_bad)    st_n = ST_VOFF_NG;
        else if (at_end) st_n = ST_VOFF_OK;
        else             st_n = ST_DUMMY;
      end
      ST_VOFF_OK: if (t_exp) st_n = ST_WOFF_OK;
      ST_VOFF_NG: if (t_exp) st_n = at_limit ? ST_WOFF_NG : ST_SETUP;
      ST_WOFF_OK: if (t_exp) st_n = ST_IDLE;
      ST_WOFF_NG: if (t_exp) st_n = ST_IDLE;
      default:    st_n = ST_IDLE;
    endcase
  end

  // delay chosen by the state being entered
  always_comb begin
    case (st_n)
      ST_WEN:                 t_val = dly_wen_on;
      ST_SETUP:               t_val = dly_setup;
      ST_ERASE:               t_val = dly_erase;
      ST_EOFF:                t_val = dly_erase_off;
      ST_SOFF:                t_val = dly_setup_off;
      ST_VON:                 t_val = dly_verify_on;
      ST_SETTLE:              t_val = dly_read;
      ST_VOFF_OK, ST_VOFF_NG: t_val = dly_verify_off;
      ST_WOFF_OK, ST_WOFF_NG: t_val = dly_wen_off;
      default:                t_val = '0;
    endcase
  end
  assign t_load = (st_n != st);

  seq_wait_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .expired(t_exp));

  seq_addr_walk #(.AW(AW)) u_walk (
    .clk(clk), .rst_n(rst_n), .load(addr_load), .inc(addr_inc),
    .first(blk_first), .last(blk_last), .addr(vaddr), .at_end(at_end));

  seq_try_count #(.TW(TW)) u_tries (
    .clk(clk), .rst_n(rst_n), .clear(start_accept), .inc(retry),
    .limit(try_limit), .at_limit(at_limit));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      done   <= 1'b0;
      fail   <= 1'b0;
      status <= STAT_NONE;
    end else begin
      st   <= st_n;
      done <= finish_ok;
      fail <= finish_ng || start_reject;
      if (start_accept)      status <= STAT_NONE;
      else if (start_reject) status <= STAT_REJECT;
      else if (finish_ok)    status <= STAT_PASS;
      else if (finish_ng)    status <= STAT_FAIL;
    end
  end

  // strobe decode
  assign busy        = (st != ST_IDLE);
  assign write_en    = !(st inside {ST_IDLE, ST_WOFF_OK, ST_WOFF_NG});
  assign wdog_en     = st inside {ST_SETUP, ST_ERASE, ST_EOFF, ST_SOFF};
  assign erase_setup = st inside {ST_SETUP, ST_ERASE, ST_EOFF};
  assign erase_on    = (st == ST_ERASE);
  assign verify_on   = st inside {ST_VON, ST_DUMMY, ST_SETTLE, ST_READ};
  assign dummy_wr    = (st == ST_DUMMY);
  assign dummy_data  = DUMMY_BYTE;

  AST_ERASE_NESTED: assert property (@(posedge clk) disable iff (!rst_n)
    erase_on |-> (erase_setup && wdog_en && write_en)); // R3
  AST_VERIFY_NO_WDOG: assert property (@(posedge clk) disable iff (!rst_n)
    verify_on |-> (!wdog_en && !erase_setup)); // R3
  AST_DUMMY_IN_VERIFY: assert property (@(posedge clk) disable iff (!rst_n)
    dummy_wr |-> (verify_on && write_en)); // R4
  AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    start_reject |=> (fail && !busy && !write_en && status == STAT_REJECT)); // R1
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start_accept |=> (busy && write_en && !wdog_en && status == STAT_NONE)); // R8
  AST_RESULT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fail) |-> !busy); // R8
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fail)); // R9
  AST_DONE_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (status == STAT_PASS)); // R6
  AST_FAIL_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> (status == STAT_FAIL || status == STAT_REJECT)); // R7
endmodule

// File: tb/flash_erase_seq_test.sv
module flash_erase_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 12, CW = 8, TW = 4, NBLK = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [NBLK-1:0] blk_mask = '0;
  logic [AW-1:0] blk_first = '0, blk_last = '0;
  logic [CW-1:0] dx = 0, dy = 0, dz = 0, da = 0, db = 0, dg = 0, de = 0, dh = 0, dt = 0;
  logic [TW-1:0] try_limit = '0;
  logic [15:0] vdata;
  logic write_en, erase_setup, erase_on, verify_on, wdog_en, dummy_wr, busy, done, fail;
  logic [AW-1:0] vaddr;
  logic [7:0] dummy_data;
  logic [1:0] status;

  int checks = 0, errors = 0;
  int need [16];
  int ecount = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_erase_seq #(.AW(AW), .CW(CW), .TW(TW), .NBLK(NBLK)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .blk_mask(blk_mask),
    .blk_first(blk_first), .blk_last(blk_last),
    .dly_wen_on(dx), .dly_setup(dy), .dly_erase(dz), .dly_erase_off(da),
    .dly_setup_off(db), .dly_verify_on(dg), .dly_read(de),
    .dly_verify_off(dh), .dly_wen_off(dt), .try_limit(try_limit),
    .vdata(vdata), .write_en(write_en), .erase_setup(erase_setup),
    .erase_on(erase_on), .verify_on(verify_on), .wdog_en(wdog_en),
    .vaddr(vaddr), .dummy_wr(dummy_wr), .dummy_data(dummy_data),
    .busy(busy), .done(done), .fail(fail), .status(status));

  // array model: word i reads erased once ecount >= need[i]; else one zero bit
  function automatic logic [15:0] model_word(input int idx);
    if (idx < 0 || idx > 15) return 16'h0000;
    if (ecount >= need[idx]) return 16'hFFFF;
    return 16'hFFFF ^ (16'h1 << idx);
  endfunction

  always_comb vdata = model_word(int'(vaddr) - int'(blk_first));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // expected outcome from the requirements
  task automatic predict(input int sz, input int lim, output int passed,
                         output int tries, output int cycles);
    int eff = (lim == 0) ? 1 : lim;
    cycles = dx + 1 + dt + 1;
    passed = 0;
    tries = 0;
    for (int a = 1; a <= eff; a++) begin
      int w = sz;
      for (int i = sz - 1; i >= 0; i--) if (need[i] > a) w = i + 1;
      tries = a;
      cycles += dy + dz + da + db + dg + 5 + dh + 1 + w * (de + 3);
      if (w == sz && need[sz-1] <= a) begin passed = 1; break; end
    end
  endtask

  task automatic run_case(input string name, input int sz, input int lim,
                          input int poke_busy);
    int passed, tries, cyc, busy_n = 0, pre_wdog = 0, seen_wdog = 0;
    int erase_run = 0, erase_bad = 0, dummies = 0, addr_bad = 0, order_bad = 0;
    int exp_addr, exp_dummies = 0, guard = 0;
    predict(sz, lim, passed, tries, cyc);
    @(negedge clk);
    ecount = 0;
    try_limit = TW'(lim);
    blk_mask = NBLK'(1) << ($urandom % NBLK);
    blk_first = AW'(16 * ($urandom % 200));
    blk_last = blk_first + AW'(sz - 1);
    exp_addr = int'(blk_first);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!(done || fail) && guard < 20000) begin
      guard++;
      if (busy) busy_n++;
      if (poke_busy != 0 && busy_n == 5) start = 1'b1; else start = 1'b0;
      if (wdog_en) seen_wdog = 1;
      if (!seen_wdog && busy) begin
        pre_wdog++;
        if (!write_en || erase_setup) order_bad++;
      end
      if (erase_on) erase_run++;
      else if (erase_run != 0) begin
        if (erase_run != dz + 1) erase_bad++;
        erase_run = 0;
      end
      if (erase_on && erase_run == 1) ecount++;
      if (verify_on && wdog_en) order_bad++;
      if (dummy_wr) begin
        dummies++;
        if (int'(vaddr) != exp_addr || dummy_data != 8'hFF || !verify_on) addr_bad++;
        if (model_word(exp_addr - int'(blk_first)) != 16'hFFFF) exp_addr = int'(blk_first);
        else if (exp_addr < int'(blk_last)) exp_addr++;
      end
      @(negedge clk);
    end
    start = 1'b0;
    if (guard >= 20000) chk({name, " watchdog expired"}, 1, 0);
    for (int a = 1; a <= tries; a++) begin
      int w = sz;
      for (int i = sz - 1; i >= 0; i--) if (need[i] > a) w = i + 1;
      exp_dummies += w;
    end
    chk({name, " R10 busy cycles"}, busy_n, cyc);
    chk({name, " R2 write-enable lead"}, pre_wdog, dx + 1);
    chk({name, " R3 erase width/order"}, erase_bad + order_bad, 0);
    chk({name, " R7 attempts"}, ecount, tries);
    chk({name, " R4 dummy writes"}, dummies, exp_dummies);
    chk({name, " R4 R5 address walk"}, addr_bad, 0);
    chk({name, " R6 R7 outcome done"}, int'(done), passed);
    chk({name, " R6 R7 outcome fail"}, int'(fail), 1 - passed);
    chk({name, " R8 busy low at result"}, int'(busy), 0);
    chk({name, " R9 status"}, int'(status), passed ? 1 : 2);
    @(negedge clk);
    chk({name, " R9 pulse ends"}, int'(done || fail), 0);
    chk({name, " R9 status sticky"}, int'(status), passed ? 1 : 2);
    chk({name, " R8 no restart"}, int'(busy), 0);
  endtask

  task automatic reject_case(input string name, input logic [NBLK-1:0] m);
    @(negedge clk);
    blk_mask = m;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk({name, " R1 fail pulse"}, int'(fail), 1);
    chk({name, " R1 no busy"}, int'(busy), 0);
    chk({name, " R1 no strobe"}, int'(write_en || wdog_en || erase_setup), 0);
    chk({name, " R1 status rejected"}, int'(status), 3);
    @(negedge clk);
    chk({name, " R1 stays idle"}, int'(busy || write_en), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 16; i++) need[i] = 1;
    repeat (3) @(negedge clk);
    chk("R9 reset status", int'(status), 0);
    chk("R8 reset busy", int'(busy), 0);
    chk("R2 reset write_en", int'(write_en), 0);
    rst_n = 1'b1;
    @(negedge clk);

    reject_case("empty mask", '0);
    reject_case("two-bit mask", 8'b0001_0100);

    // directed: single word, first attempt passes, zero delays
    dx = 0; dy = 0; dz = 0; da = 0; db = 0; dg = 0; de = 0; dh = 0; dt = 0;
    run_case("one word", 1, 1, 0);

    // directed: stubborn last word, passes on attempt 2 of 3; start poked while busy
    dx = 2; dy = 1; dz = 3; da = 1; db = 2; dg = 1; de = 2; dh = 1; dt = 3;
    for (int i = 0; i < 4; i++) need[i] = 1;
    need[3] = 2;
    run_case("retry pass", 4, 3, 1);

    // directed: never erases, limit 2 -> fail
    for (int i = 0; i < 3; i++) need[i] = 99;
    run_case("exhausted", 3, 2, 0);

    // directed: limit 0 behaves as one attempt
    need[0] = 1; need[1] = 2;
    run_case("limit zero", 2, 0, 0);

    for (int k = 0; k < 10; k++) begin
      int sz = 1 + ($urandom % 8);
      dx = CW'($urandom % 4); dy = CW'($urandom % 4); dz = CW'($urandom % 4);
      da = CW'($urandom % 4); db = CW'($urandom % 4); dg = CW'($urandom % 4);
      de = CW'($urandom % 4); dh = CW'($urandom % 4); dt = CW'($urandom % 4);
      for (int i = 0; i < 16; i++) need[i] = (($urandom % 6) == 0) ? 99 : 1 + ($urandom % 3);
      run_case($sformatf("random %0d", k), sz, $urandom % 5, k % 2);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule